// File: doc/BRIEF.md
# Low-Power-Aware Watchdog Timer

This block is a watchdog that counts ticks from a slow periodic time base. When the programmed period runs out before software restarts it, the block raises a chip-reset pulse one clock wide. A write-only 8-bit mode register selects the period and decides whether counting continues while the device sits in HALT or in STOP. A time-out that occurs while the device is in STOP also raises a stop-recovery pulse, so the watchdog can act as an alarm clock that brings the device out of STOP within a bounded time.

The period comes from two fields of the mode register. A three-bit long-range field picks 320, 1280 or 5120 units when exactly one of its bits is set. In every other case a two-bit short-range field picks 5, 10, 20 or 80 units. Each unit is `TICKS_PER_UNIT` ticks. Power-on reset loads the register. A stop-mode-recovery reset restarts the count but leaves the register alone. The block has no read path, so its contents never reach a read bus.

Top module: `lpw_top`

## Requirements
- R1: While power-on reset is low and in the first cycle after it, the reset and recovery outputs are low. The mode register powers up as 0x0D: short code 01 (10 units), HALT counting on, STOP counting on.
- R2: With mode bits [6:4]=000, bits [1:0] select the period: 00 gives 5 units, 01 gives 10, 10 gives 20 and 11 gives 80. The period is units x `TICKS_PER_UNIT` counted ticks, measured from the last restart.
- R3: With exactly one bit set in [6:4], the period is 320 units for 001, 1280 units for 010 and 5120 units for 100. Bits [1:0] have no effect on it.
- R4: With two or three bits set in [6:4], the period is chosen by bits [1:0] exactly as in R2.
- R5: Bit 2 set means ticks are counted in HALT. When bit 2 is clear and `halt_i` is high, ticks are ignored and the count holds.
- R6: Bit 3 set means ticks are counted in STOP. When bit 3 is clear and `stop_i` is high, ticks are ignored and the count holds.
- R7: A clear strobe restarts the count from zero. So does a mode write, which takes priority over the clear and over a tick in the same cycle. Bit 7 is stored nowhere and has no effect.
- R8: `wdt_rst_o` is high for exactly one clock, in the cycle after the edge on which the final tick of the period was counted. After that the count restarts from zero with the same configuration.
- R9: `stop_wake_o` pulses together with `wdt_rst_o` when `stop_i` was high on that edge. It is never high without `wdt_rst_o`.
- R10: `smr_i` (stop-mode-recovery reset) zeroes the count and both outputs on the next edge. It does not change the mode register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| por_ni | input | 1 | Asynchronous power-on reset, active low |
| smr_i | input | 1 | Stop-mode-recovery reset, synchronous, active high |
| mode_we_i | input | 1 | Mode register write strobe |
| mode_wdata_i | input | 8 | Mode register write data |
| kick_i | input | 1 | Watchdog clear strobe |
| halt_i | input | 1 | Device is in HALT |
| stop_i | input | 1 | Device is in STOP |
| tick_i | input | 1 | Time-base tick, one clock wide |
| wdt_rst_o | output | 1 | Chip reset request pulse |
| stop_wake_o | output | 1 | Stop-recovery pulse |

## Verification
The last counted tick of a period is sampled at a rising edge, and both output pulses are registered at that same edge. They are therefore due one cycle later and last one cycle. A write, a clear or `smr_i` acts on the count at the first edge that samples it. The bench drives inputs and samples outputs on falling edges. A behavioural model advances on the same rising edges and is compared with the outputs on every cycle. Directed scenarios then count the falling edges between a restart and the first reset pulse and compare that count with units x ticks per unit.

// File: rtl/lpw_pkg.sv
package lpw_pkg;

    // Stored part of the mode register (bit 7 is reserved and not kept).
    // Field order matches bit positions 6..0 because the decoder relies on them.
    typedef struct packed {
        logic [2:0] long_sel;   // bits 6:4
        logic       stop_run;   // bit 3
        logic       halt_run;   // bit 2
        logic [1:0] short_sel;  // bits 1:0
    } mode_t;

    localparam int unsigned MODE_W    = 7;
    localparam logic [6:0]  MODE_POR  = 7'h0D;
    localparam int unsigned LONG_N    = 3;
    localparam int unsigned MAX_UNITS = 5120;
    localparam int unsigned UNIT_W    = $clog2(MAX_UNITS + 1);

    function automatic logic [UNIT_W-1:0] long_units(input int unsigned k);
        case (k)
            0:       return UNIT_W'(320);
            1:       return UNIT_W'(1280);
            default: return UNIT_W'(5120);
        endcase
    endfunction

    function automatic logic [UNIT_W-1:0] short_units(input logic [1:0] code);
        case (code)
            2'b00:   return UNIT_W'(5);
            2'b01:   return UNIT_W'(10);
            2'b10:   return UNIT_W'(20);
            default: return UNIT_W'(80);
        endcase
    endfunction

endpackage

// File: rtl/lpw_mode_reg.sv
module lpw_mode_reg
    import lpw_pkg::*;
(
    input  logic        clk_i,
    input  logic        por_ni,
    input  logic        smr_i,
    input  logic        we_i,
    input  logic [6:0]  wdata_i,
    output mode_t       mode_o
);

    typedef struct packed {
        mode_t mode;
    } reg_state_t;

    reg_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we_i) begin
            st_d.mode = mode_t'(wdata_i);
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            st_q.mode <= mode_t'(MODE_POR);
        end else begin
            st_q <= st_d;
        end
    end

    assign mode_o = st_q.mode;

    // A recovery reset with no write leaves the configuration untouched
    assert_mode_kept_smr_R10: assert property (@(posedge clk_i) disable iff (!por_ni)
        (smr_i && !we_i) |=> $stable(mode_o));

    // Without a write the stored mode never changes
    assert_mode_hold_R7: assert property (@(posedge clk_i) disable iff (!por_ni)
        !we_i |=> $stable(mode_o));

endmodule

// File: rtl/lpw_period_dec.sv
module lpw_period_dec
    import lpw_pkg::*;
#(
    parameter int unsigned TICKS_PER_UNIT = 1,
    parameter int unsigned CNT_W          = 13
) (
    input  logic [2:0]       long_sel_i,
    input  logic [1:0]       short_sel_i,
    output logic [CNT_W-1:0] limit_o
);

    logic [LONG_N-1:0] hit;
    logic [UNIT_W-1:0] units;

    // One comparator per long-range code: only an exact single-bit pattern hits
    for (genvar k = 0; k < LONG_N; k++) begin : g_long
        assign hit[k] = (long_sel_i == 3'(1 << k));
    end

    always_comb begin
        units = short_units(short_sel_i);
        for (int k = 0; k < LONG_N; k++) begin
            if (hit[k]) begin
                units = long_units(k);
            end
        end
    end

    assign limit_o = CNT_W'(32'(units) * TICKS_PER_UNIT);

    // Long-range codes are mutually exclusive
    always_comb begin
        assert_long_onehot_R3: assert ($onehot0(hit));
    end

endmodule

// File: rtl/lpw_counter.sv
module lpw_counter #(
    parameter int unsigned CNT_W = 13
) (
    input  logic             clk_i,
    input  logic             por_ni,
    input  logic             smr_i,
    input  logic             clr_i,
    input  logic             step_i,
    input  logic             in_stop_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             bite_o,
    output logic             wake_o
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             bite;
        logic             wake;
    } cnt_state_t;

    cnt_state_t st_d, st_q;
    logic       last;

    assign last = (st_q.cnt + CNT_W'(1)) >= limit_i;

    always_comb begin
        st_d      = st_q;
        st_d.bite = 1'b0;
        st_d.wake = 1'b0;
        if (smr_i || clr_i) begin
            st_d.cnt = '0;
        end else if (step_i) begin
            if (last) begin
                st_d.cnt  = '0;
                st_d.bite = 1'b1;
                st_d.wake = in_stop_i;
            end else begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end
    end

    always_ff @(posedge clk_i or negedge por_ni) begin
        if (!por_ni) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign bite_o = st_q.bite;
    assign wake_o = st_q.wake;

    assert_single_pulse_R8: assert property (@(posedge clk_i) disable iff (!por_ni)
        bite_o |=> !bite_o);

    assert_wake_needs_bite_R9: assert property (@(posedge clk_i) disable iff (!por_ni)
        wake_o |-> bite_o);

    assert_restart_after_bite_R8: assert property (@(posedge clk_i) disable iff (!por_ni)
        bite_o |-> (st_q.cnt == '0));

    assert_clear_zeroes_R7: assert property (@(posedge clk_i) disable iff (!por_ni)
        clr_i |=> (st_q.cnt == '0 && !bite_o));

    assert_smr_zeroes_R10: assert property (@(posedge clk_i) disable iff (!por_ni)
        smr_i |=> (st_q.cnt == '0 && !bite_o && !wake_o));

    assert_gated_hold_R5: assert property (@(posedge clk_i) disable iff (!por_ni)
        (!step_i && !clr_i && !smr_i) |=> ($stable(st_q.cnt) && !bite_o));

endmodule

// File: rtl/lpw_top.sv
module lpw_top
    import lpw_pkg::*;
#(
    parameter int unsigned TICKS_PER_UNIT = 1
) (
    input  logic       clk_i,
    input  logic       por_ni,
    input  logic       smr_i,
    input  logic       mode_we_i,
    input  logic [7:0] mode_wdata_i,
    input  logic       kick_i,
    input  logic       halt_i,
    input  logic       stop_i,
    input  logic       tick_i,
    output logic       wdt_rst_o,
    output logic       stop_wake_o
);

    localparam int unsigned CNT_W = $clog2(MAX_UNITS * TICKS_PER_UNIT + 1);

    mode_t            mode;
    logic [CNT_W-1:0] limit;
    logic             run_ok;
    logic             step;
    logic             clr;
    logic             rsvd_unused;

    assign rsvd_unused = mode_wdata_i[7];

    lpw_mode_reg u_mode (
        .clk_i   (clk_i),
        .por_ni  (por_ni),
        .smr_i   (smr_i),
        .we_i    (mode_we_i),
        .wdata_i (mode_wdata_i[6:0]),
        .mode_o  (mode)
    );

    lpw_period_dec #(
        .TICKS_PER_UNIT (TICKS_PER_UNIT),
        .CNT_W          (CNT_W)
    ) u_dec (
        .long_sel_i  (mode.long_sel),
        .short_sel_i (mode.short_sel),
        .limit_o     (limit)
    );

    // Each low-power state vetoes counting unless its enable bit is set
    assign run_ok = !(stop_i && !mode.stop_run) && !(halt_i && !mode.halt_run);
    assign step   = tick_i && run_ok;
    assign clr    = mode_we_i || kick_i;

    lpw_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk_i     (clk_i),
        .por_ni    (por_ni),
        .smr_i     (smr_i),
        .clr_i     (clr),
        .step_i    (step),
        .in_stop_i (stop_i),
        .limit_i   (limit),
        .bite_o    (wdt_rst_o),
        .wake_o    (stop_wake_o)
    );

    assert_stop_gate_R6: assert property (@(posedge clk_i) disable iff (!por_ni)
        (stop_i && !mode.stop_run && !smr_i) |=> !wdt_rst_o);

    assert_halt_gate_R5: assert property (@(posedge clk_i) disable iff (!por_ni)
        (halt_i && !mode.halt_run && !smr_i) |=> !wdt_rst_o);

endmodule

// File: tb/lpw_top_tb.sv
module lpw_top_tb;

    localparam int unsigned TPU = 2;

    logic       clk = 1'b0;
    logic       por_n = 1'b0;
    logic       smr = 1'b0;
    logic       we = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic       kick = 1'b0;
    logic       halt = 1'b0;
    logic       stop = 1'b0;
    logic       tick = 1'b0;
    logic       rst_o;
    logic       wake_o;

    int    checks = 0;
    int    fails = 0;
    int    cycles = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    lpw_top #(.TICKS_PER_UNIT(TPU)) u_dut (
        .clk_i        (clk),
        .por_ni       (por_n),
        .smr_i        (smr),
        .mode_we_i    (we),
        .mode_wdata_i (wdata),
        .kick_i       (kick),
        .halt_i       (halt),
        .stop_i       (stop),
        .tick_i       (tick),
        .wdt_rst_o    (rst_o),
        .stop_wake_o  (wake_o)
    );

    // ---------------- behavioural reference ----------------
    logic [7:0] m_cfg;
    int         m_cnt;
    logic       m_rst, m_wake;

    function automatic int period_of(input logic [7:0] c);
        int u;
        if ($countones(c[6:4]) == 1) u = c[4] ? 320 : (c[5] ? 1280 : 5120);
        else if (c[1:0] == 2'd0) u = 5;
        else if (c[1:0] == 2'd1) u = 10;
        else if (c[1:0] == 2'd2) u = 20;
        else u = 80;
        return u * TPU;
    endfunction

    always @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            m_cfg <= 8'h0D; m_cnt <= 0; m_rst <= 1'b0; m_wake <= 1'b0;
        end else begin
            m_rst <= 1'b0; m_wake <= 1'b0;
            if (we) m_cfg <= wdata;
            if (smr || we || kick) m_cnt <= 0;
            else if (tick && !(halt && !m_cfg[2]) && !(stop && !m_cfg[3])) begin
                if (m_cnt + 1 == period_of(m_cfg)) begin
                    m_cnt <= 0; m_rst <= 1'b1; m_wake <= stop;
                end else m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        check(cur_req, "reset pulse vs model", int'(rst_o), int'(m_rst));
        check(cur_req, "wake pulse vs model", int'(wake_o), int'(m_wake));
        if (cycles > 150000) begin
            fails++; checks++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", cycles);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic write_mode(input logic [7:0] v);
        @(negedge clk); we = 1'b1; wdata = v;
        @(negedge clk); we = 1'b0;
    endtask

    // Ticks every cycle from the next edge; returns edges until the reset pulse
    task automatic run_to_bite(output int n, output bit wk);
        n = 0; wk = 1'b0; tick = 1'b1;
        while (n < 20000) begin
            @(negedge clk); n++;
            if (rst_o) begin wk = wake_o; break; end
        end
        tick = 1'b0;
    endtask

    task automatic measure(input logic [7:0] v, input int exp_units, input string req);
        int n; bit wk;
        cur_req = req;
        write_mode(v);
        run_to_bite(n, wk);
        check(req, $sformatf("period for mode %02h", v), n, exp_units * TPU);
    endtask

    task automatic tick_n(input int k, output bit saw);
        saw = 1'b0; tick = 1'b1;
        repeat (k) begin @(negedge clk); if (rst_o) saw = 1'b1; end
        tick = 1'b0;
    endtask

    initial begin
        int n; bit wk; bit saw;
        // R1: outputs low under reset and right after release
        repeat (3) @(negedge clk);
        check("R1", "reset held rst_o", int'(rst_o), 0);
        por_n = 1'b1;
        @(negedge clk);
        check("R1", "after release rst_o", int'(rst_o), 0);
        check("R1", "after release wake_o", int'(wake_o), 0);
        // R1: default mode gives 10 units and counts in STOP (wake pulse)
        cur_req = "R1";
        stop = 1'b1;
        run_to_bite(n, wk);
        check("R1", "power-on period", n, 10 * TPU);
        check("R9", "wake with stop at expiry", int'(wk), 1);
        stop = 1'b0;
        // R8: pulse one clock wide and restart with same config
        cur_req = "R8";
        @(negedge clk);
        check("R8", "pulse width", int'(rst_o), 0);
        run_to_bite(n, wk);
        check("R8", "second period after restart", n, 10 * TPU);
        check("R9", "no wake outside stop", int'(wk), 0);
        // R2: short field
        measure(8'h00, 5, "R2");
        measure(8'h01, 10, "R2");
        measure(8'h02, 20, "R2");
        measure(8'h03, 80, "R2");
        // R3: long field, short bits ignored
        measure(8'h13, 320, "R3");
        measure(8'h20, 1280, "R3");
        measure(8'h42, 5120, "R3");
        // R4: fallback when several long bits are set
        measure(8'h30, 5, "R4");
        measure(8'h61, 10, "R4");
        measure(8'h53, 80, "R4");
        measure(8'h72, 20, "R4");
        // R7: reserved bit has no effect
        measure(8'h80, 5, "R7");
        // R5: HALT gating, period 5 units with both run bits clear
        cur_req = "R5";
        write_mode(8'h00);
        tick_n(4, saw);
        halt = 1'b1;
        tick_n(40, saw);
        check("R5", "no bite while halted and gated", int'(saw), 0);
        halt = 1'b0;
        run_to_bite(n, wk);
        check("R5", "remaining ticks after halt", n, 5 * TPU - 4);
        // R5: HALT counting enabled
        write_mode(8'h04);
        halt = 1'b1;
        run_to_bite(n, wk);
        check("R5", "counting in halt when enabled", n, 5 * TPU);
        halt = 1'b0;
        // R6: STOP gating
        cur_req = "R6";
        write_mode(8'h00);
        tick_n(3, saw);
        stop = 1'b1;
        tick_n(40, saw);
        check("R6", "no bite while stopped and gated", int'(saw), 0);
        stop = 1'b0;
        run_to_bite(n, wk);
        check("R6", "remaining ticks after stop", n, 5 * TPU - 3);
        write_mode(8'h08);
        stop = 1'b1;
        run_to_bite(n, wk);
        check("R6", "counting in stop when enabled", n, 5 * TPU);
        check("R9", "stop-recovery pulse", int'(wk), 1);
        stop = 1'b0;
        // R7: clear strobe restarts
        cur_req = "R7";
        write_mode(8'h01);
        tick_n(15, saw);
        @(negedge clk); kick = 1'b1;
        @(negedge clk); kick = 1'b0;
        run_to_bite(n, wk);
        check("R7", "period after clear", n, 10 * TPU);
        // R7: write with tick and clear in same cycle restarts, new mode applies
        tick_n(7, saw);
        @(negedge clk); we = 1'b1; wdata = 8'h00; kick = 1'b1; tick = 1'b1;
        @(negedge clk); we = 1'b0; kick = 1'b0; tick = 1'b0;
        run_to_bite(n, wk);
        check("R7", "period after write priority", n, 5 * TPU);
        // R10: recovery reset clears count, keeps mode
        cur_req = "R10";
        write_mode(8'h02);
        tick_n(30, saw);
        @(negedge clk); smr = 1'b1;
        @(negedge clk); smr = 1'b0;
        check("R10", "outputs low after smr", int'(rst_o), 0);
        run_to_bite(n, wk);
        check("R10", "full kept period after smr", n, 20 * TPU);
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule